// File: doc/BRIEF.md
# Dual-Port Synchronous Memory with Cross-Port Forwarding

This block is a word-wide synchronous memory shared by two independent ports, X and Y. Each port has its own address, write-data input, read-data output, write strobe and a pair of chip enables. Each port also has a forward control and an output enable. All inputs except the output enables are sampled on the rising edge of one clock. Read data leaves through a per-port output register. Both ports may read or write the shared array in the same cycle.

A port can also forward its sampled write-data input to the other port's output register. The forwarded word then replaces any array word that port would have shown. When both ports hit the same address in one cycle, fixed rules decide the result: reads see the contents from before the cycle, and a write from Y beats a write from X.

Data input and data output are kept on separate buses. Each port has a drive-enable so the pad ring can build a bidirectional pin. The output enable gates that drive-enable combinationally.

A two-state phase sequencer governs input acceptance:
- `PH_WARM` is entered on reset. Inputs sampled at this edge are dropped.
- The transition `PH_WARM -> PH_RUN` is taken on the first rising edge after reset is released.
- `PH_RUN -> PH_RUN` holds until the next reset.

Each port's sampled inputs decode to one of three operation states: `OP_IDLE`, `OP_READ` or `OP_WRITE`. The output register of each port picks its source each cycle. The sources are `SRC_PASS` (word forwarded from the other port), `SRC_ARRAY` (array read) and `SRC_NONE` (nothing new loaded).

Top module: `dpsram_dual`

## Requirements
- R1: A read sampled at rising edge k appears on the port's data output after edge k+1. After edge k alone, the drive-enable still reflects the previous cycle (low when that cycle was idle).
- R2: A port is selected only when its low-true chip enable is 0 and its high-true chip enable is 1. With any other pair, the port's write is ignored, its forward is ignored and it starts no read.
- R3: A selected port with its write strobe at 0 stores its sampled data word at its sampled address. With the strobe at 1, it reads that address.
- R4: The output enable is not registered. Output enable 1 drops the port's drive-enable at once, and 0 restores it, with no clock edge needed.
- R5: A selected port X with its forward control at 0 sends its sampled data word to port Y's output, with the same latency as a read. This replaces any array word Y would have shown.
- R6: A selected port Y with its forward control at 0 sends its sampled data word to port X's output in the same way. When both ports forward in one cycle, the two words swap.
- R7: Two reads of the same address in one cycle both return the stored word.
- R8: When one port writes and the other reads the same address in one cycle, the reader gets the word stored before that cycle. The new word is stored afterwards.
- R9: When both ports write the same address in one cycle, only the port Y word is stored.
- R10: The first rising edge after reset is released accepts no operation. Operations sampled from the second edge on take effect.
- R11: With parameter IDLE_Z=1 (the default), a port's drive-enable goes low one edge after a cycle with no read and no forward toward it. With IDLE_Z=0, the last word is held instead.
- R12: During reset both drive-enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, low true |
| x_addr | input | AW | Port X word address |
| x_din | input | DW | Port X write / forward data |
| x_ce_n | input | 1 | Port X chip enable, low true |
| x_ce | input | 1 | Port X chip enable, high true |
| x_wr_n | input | 1 | Port X write strobe, low true |
| x_pass_n | input | 1 | Port X forward-to-Y control, low true |
| x_oe_n | input | 1 | Port X output enable, low true, unregistered |
| x_dout | output | DW | Port X output register |
| x_dout_en | output | 1 | Port X pad drive-enable |
| y_addr | input | AW | Port Y word address |
| y_din | input | DW | Port Y write / forward data |
| y_ce_n | input | 1 | Port Y chip enable, low true |
| y_ce | input | 1 | Port Y chip enable, high true |
| y_wr_n | input | 1 | Port Y write strobe, low true |
| y_pass_n | input | 1 | Port Y forward-to-X control, low true |
| y_oe_n | input | 1 | Port Y output enable, low true, unregistered |
| y_dout | output | DW | Port Y output register |
| y_dout_en | output | 1 | Port Y pad drive-enable |

## Verification
Two collisions can fall in one cycle. The first is an array access on one port against a write to the same address on the other. The second is a forward toward a port against that port's own array read. The bench first fills every address from one port and then from the other, using arithmetic patterns. It then drives both ports in the same cycle with equal addresses, or with one port forwarding while the other reads. Each port's output is judged against the pattern word expected from before the cycle, or against the forwarded word. A follow-up read judges what the array kept.

// File: rtl/dpsram_pkg.sv
package dpsram_pkg;

    // Decoded operation of one port after input capture
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;

    // Acceptance phase after reset
    typedef enum logic {
        PH_WARM = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Source picked by an output register
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ARRAY = 2'd1,
        SRC_PASS  = 2'd2
    } out_src_e;

endpackage

// File: rtl/dpsram_port_in.sv
module dpsram_port_in
    import dpsram_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] din_i,
    input  logic          ce_n_i,
    input  logic          ce_i,
    input  logic          wr_n_i,
    input  logic          pass_n_i,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output port_op_e      op_q,
    output logic          fwd_q
);

    logic     picked;
    port_op_e op_d;

    assign picked = run & ~ce_n_i & ce_i;

    always_comb begin
        unique case ({picked, wr_n_i})
            2'b11:   op_d = OP_READ;
            2'b10:   op_d = OP_WRITE;
            default: op_d = OP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            fwd_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            op_q   <= op_d;
            fwd_q  <= picked & ~pass_n_i;
            addr_q <= addr_i;
            data_q <= din_i;
        end
    end

    // R2
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(~ce_n_i & ce_i) |=> (op_q == OP_IDLE) && !fwd_q);

endmodule

// File: rtl/dpsram_core.sv
module dpsram_core
    import dpsram_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr [2],
    input  logic [DW-1:0] data [2],
    input  port_op_e      op   [2],
    output logic [DW-1:0] rd   [2]
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Port Y is applied last so it wins a shared address; reads use the
    // contents from before this edge.
    always_ff @(posedge clk) begin
        if (op[0] == OP_WRITE) mem[addr[0]] <= data[0];
        if (op[1] == OP_WRITE) mem[addr[1]] <= data[1];
    end

    genvar g;
    for (g = 0; g < 2; g++) begin : g_rd
        assign rd[g] = mem[addr[g]];
    end

    // R9
    y_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op[0] == OP_WRITE && op[1] == OP_WRITE && addr[0] == addr[1])
        |=> mem[$past(addr[1])] == $past(data[1]));

endmodule

// File: rtl/dpsram_out_reg.sv
module dpsram_out_reg
    import dpsram_pkg::*;
#(
    parameter int DW     = 36,
    parameter bit IDLE_Z = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  port_op_e      own_op,
    input  logic [DW-1:0] rd_data,
    input  logic          fwd_in,
    input  logic [DW-1:0] fwd_data,
    input  logic          oe_n,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    out_src_e      src;
    logic [DW-1:0] dout_q;
    logic          valid_q;

    always_comb begin
        if (fwd_in)                   src = SRC_PASS;
        else if (own_op == OP_READ)   src = SRC_ARRAY;
        else                          src = SRC_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            unique case (src)
                SRC_PASS: begin
                    dout_q  <= fwd_data;
                    valid_q <= 1'b1;
                end
                SRC_ARRAY: begin
                    dout_q  <= rd_data;
                    valid_q <= 1'b1;
                end
                default: begin
                    if (IDLE_Z) valid_q <= 1'b0;
                end
            endcase
        end
    end

    assign dout    = dout_q;
    assign dout_en = valid_q & ~oe_n;

    // R5, R6
    fwd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_in |=> valid_q && (dout_q == $past(fwd_data)));

    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (IDLE_Z && !fwd_in && own_op != OP_READ) |=> !valid_q);

endmodule

// File: rtl/dpsram_dual.sv
module dpsram_dual
    import dpsram_pkg::*;
#(
    parameter int AW     = 4,
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter bit IDLE_Z = 1'b1,
    localparam int DW    = LANE_W * LANES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] x_addr,
    input  logic [DW-1:0] x_din,
    input  logic          x_ce_n,
    input  logic          x_ce,
    input  logic          x_wr_n,
    input  logic          x_pass_n,
    input  logic          x_oe_n,
    output logic [DW-1:0] x_dout,
    output logic          x_dout_en,
    input  logic [AW-1:0] y_addr,
    input  logic [DW-1:0] y_din,
    input  logic          y_ce_n,
    input  logic          y_ce,
    input  logic          y_wr_n,
    input  logic          y_pass_n,
    input  logic          y_oe_n,
    output logic [DW-1:0] y_dout,
    output logic          y_dout_en
);

    phase_e phase_q, phase_d;
    logic   run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_WARM;
        else        phase_q <= phase_d;
    end

    always_comb begin
        unique case (phase_q)
            PH_WARM: phase_d = PH_RUN;
            PH_RUN:  phase_d = PH_RUN;
        endcase
        run = (phase_q == PH_RUN);
    end

    // Port-indexed views: index 0 is X, index 1 is Y
    logic [AW-1:0] p_addr [2];
    logic [DW-1:0] p_din  [2];
    logic          p_ce_n [2];
    logic          p_ce   [2];
    logic          p_wr_n [2];
    logic          p_pass [2];
    logic          p_oe_n [2];
    logic [DW-1:0] p_dout [2];
    logic          p_en   [2];

    assign p_addr[0] = x_addr;   assign p_addr[1] = y_addr;
    assign p_din[0]  = x_din;    assign p_din[1]  = y_din;
    assign p_ce_n[0] = x_ce_n;   assign p_ce_n[1] = y_ce_n;
    assign p_ce[0]   = x_ce;     assign p_ce[1]   = y_ce;
    assign p_wr_n[0] = x_wr_n;   assign p_wr_n[1] = y_wr_n;
    assign p_pass[0] = x_pass_n; assign p_pass[1] = y_pass_n;
    assign p_oe_n[0] = x_oe_n;   assign p_oe_n[1] = y_oe_n;

    assign x_dout    = p_dout[0];
    assign x_dout_en = p_en[0];
    assign y_dout    = p_dout[1];
    assign y_dout_en = p_en[1];

    logic [AW-1:0] addr_q [2];
    logic [DW-1:0] data_q [2];
    port_op_e      op_q   [2];
    logic          fwd_q  [2];
    logic [DW-1:0] rd     [2];

    genvar g;
    for (g = 0; g < 2; g++) begin : g_port
        dpsram_port_in #(.AW(AW), .DW(DW)) u_in (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .addr_i   (p_addr[g]),
            .din_i    (p_din[g]),
            .ce_n_i   (p_ce_n[g]),
            .ce_i     (p_ce[g]),
            .wr_n_i   (p_wr_n[g]),
            .pass_n_i (p_pass[g]),
            .addr_q   (addr_q[g]),
            .data_q   (data_q[g]),
            .op_q     (op_q[g]),
            .fwd_q    (fwd_q[g])
        );

        dpsram_out_reg #(.DW(DW), .IDLE_Z(IDLE_Z)) u_out (
            .clk      (clk),
            .rst_n    (rst_n),
            .own_op   (op_q[g]),
            .rd_data  (rd[g]),
            .fwd_in   (fwd_q[1-g]),
            .fwd_data (data_q[1-g]),
            .oe_n     (p_oe_n[g]),
            .dout     (p_dout[g]),
            .dout_en  (p_en[g])
        );
    end

    dpsram_core #(.AW(AW), .DW(DW)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr_q),
        .data  (data_q),
        .op    (op_q),
        .rd    (rd)
    );

    // R10
    warm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WARM) |=> (op_q[0] == OP_IDLE) && (op_q[1] == OP_IDLE)
                                 && !fwd_q[0] && !fwd_q[1]);

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !x_dout_en && !y_dout_en);

endmodule

// File: tb/tb_dpsram_dual.sv
module tb_dpsram_dual;

    localparam int AW     = 4;
    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int DW     = LANE_W * LANES;
    localparam int DEPTH  = 1 << AW;
    localparam logic [1:0] SEL   = 2'b01;  // {ce_n, ce}
    localparam logic [1:0] NOSEL = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] x_addr = '0, y_addr = '0;
    logic [DW-1:0] x_din = '0, y_din = '0;
    logic x_ce_n = 1'b1, x_ce = 1'b0, x_wr_n = 1'b1, x_pass_n = 1'b1, x_oe_n = 1'b0;
    logic y_ce_n = 1'b1, y_ce = 1'b0, y_wr_n = 1'b1, y_pass_n = 1'b1, y_oe_n = 1'b0;
    logic [DW-1:0] x_dout, y_dout;
    logic x_dout_en, y_dout_en;

    int checks = 0;
    int errors = 0;
    logic          rx_en, ry_en;
    logic [DW-1:0] rx_d, ry_d;

    always #5 clk = ~clk;

    dpsram_dual #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) dut (
        .clk(clk), .rst_n(rst_n),
        .x_addr(x_addr), .x_din(x_din), .x_ce_n(x_ce_n), .x_ce(x_ce),
        .x_wr_n(x_wr_n), .x_pass_n(x_pass_n), .x_oe_n(x_oe_n),
        .x_dout(x_dout), .x_dout_en(x_dout_en),
        .y_addr(y_addr), .y_din(y_din), .y_ce_n(y_ce_n), .y_ce(y_ce),
        .y_wr_n(y_wr_n), .y_pass_n(y_pass_n), .y_oe_n(y_oe_n),
        .y_dout(y_dout), .y_dout_en(y_dout_en)
    );

    function automatic logic [DW-1:0] pat_a(int a);
        return DW'(a) * 36'h0_0F0F_1357 + 36'h0_2468_ACE1;
    endfunction

    function automatic logic [DW-1:0] pat_b(int a);
        return (DW'(a) * 36'h0_3C5A_0F19) ^ 36'h9_A5A5_0F0F;
    endfunction

    task automatic chk_val(string req, logic en, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!(en === 1'b1 && act === exp)) begin
            errors++;
            $display("FAIL %s: en=%0b data=%h expected en=1 data=%h", req, en, act, exp);
        end
    endtask

    task automatic chk_off(string req, logic en);
        checks++;
        if (en !== 1'b0) begin
            errors++;
            $display("FAIL %s: drive-enable=%0b expected 0", req, en);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle();
        x_ce_n = 1'b1; x_ce = 1'b0; x_wr_n = 1'b1; x_pass_n = 1'b1;
        y_ce_n = 1'b1; y_ce = 1'b0; y_wr_n = 1'b1; y_pass_n = 1'b1;
    endtask

    // One operation pair, then an idle cycle; results sampled after the second edge.
    task automatic cyc(input logic [1:0] xce, input logic xwe, input logic xpt,
                       input logic [AW-1:0] xa, input logic [DW-1:0] xd,
                       input logic [1:0] yce, input logic ywe, input logic ypt,
                       input logic [AW-1:0] ya, input logic [DW-1:0] yd);
        x_ce_n = xce[1]; x_ce = xce[0]; x_wr_n = ~xwe; x_pass_n = ~xpt;
        x_addr = xa; x_din = xd;
        y_ce_n = yce[1]; y_ce = yce[0]; y_wr_n = ~ywe; y_pass_n = ~ypt;
        y_addr = ya; y_din = yd;
        step();
        go_idle();
        chk_off("R1 x after first edge", x_dout_en);
        chk_off("R1 y after first edge", y_dout_en);
        step();
        rx_en = x_dout_en; rx_d = x_dout;
        ry_en = y_dout_en; ry_d = y_dout;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: cycles=200000 expected run to complete earlier");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(); step();
        chk_off("R12 x in reset", x_dout_en);
        chk_off("R12 y in reset", y_dout_en);
        rst_n = 1'b1;
        step();  // warm-up edge

        // R3: fill from X, read every word from Y; X idle shows no drive (R11)
        for (int a = 0; a < DEPTH; a++)
            cyc(SEL, 1'b1, 1'b0, AW'(a), pat_a(a), NOSEL, 1'b0, 1'b0, '0, '0);
        for (int a = 0; a < DEPTH; a++) begin
            cyc(NOSEL, 1'b0, 1'b0, '0, '0, SEL, 1'b0, 1'b0, AW'(a), '0);
            chk_val("R3 y read of x write", ry_en, ry_d, pat_a(a));
            chk_off("R11 idle x", rx_en);
        end

        // R4: unregistered output enable
        y_oe_n = 1'b1; #1;
        chk_off("R4 oe high", y_dout_en);
        y_oe_n = 1'b0; #1;
        chk_val("R4 oe low", y_dout_en, y_dout, pat_a(DEPTH-1));

        // R11: one idle edge later the drive is released
        step();
        chk_off("R11 idle y", y_dout_en);

        // R3: fill from Y, read from X
        for (int a = 0; a < DEPTH; a++)
            cyc(NOSEL, 1'b0, 1'b0, '0, '0, SEL, 1'b1, 1'b0, AW'(a), pat_b(a));
        for (int a = 0; a < DEPTH; a++) begin
            cyc(SEL, 1'b0, 1'b0, AW'(a), '0, NOSEL, 1'b0, 1'b0, '0, '0);
            chk_val("R3 x read of y write", rx_en, rx_d, pat_b(a));
        end

        // R2: every half-asserted or deasserted enable pair blocks writes and reads
        for (int c = 0; c < 4; c++) begin
            if (c == 1) continue;
            cyc(2'(c), 1'b1, 1'b0, AW'(5), 36'h0_DEAD_BEEF, 2'(c), 1'b1, 1'b0, AW'(6), 36'h0_FACE_0FF0);
            chk_off("R2 x no read when deselected", rx_en);
            cyc(SEL, 1'b0, 1'b0, AW'(5), '0, SEL, 1'b0, 1'b0, AW'(6), '0);
            chk_val("R2 x write ignored", rx_en, rx_d, pat_b(5));
            chk_val("R2 y write ignored", ry_en, ry_d, pat_b(6));
        end
        cyc(2'b11, 1'b0, 1'b1, '0, 36'h0_1111_2222, SEL, 1'b0, 1'b0, AW'(7), '0);
        chk_val("R2 forward from deselected x ignored", ry_en, ry_d, pat_b(7));

        // R7: same address read on both ports
        cyc(SEL, 1'b0, 1'b0, AW'(7), '0, SEL, 1'b0, 1'b0, AW'(7), '0);
        chk_val("R7 x", rx_en, rx_d, pat_b(7));
        chk_val("R7 y", ry_en, ry_d, pat_b(7));

        // R8: write on one port, read on the other, same address
        cyc(SEL, 1'b1, 1'b0, AW'(8), 36'h1_2345_6789, SEL, 1'b0, 1'b0, AW'(8), '0);
        chk_val("R8 y sees old word", ry_en, ry_d, pat_b(8));
        cyc(NOSEL, 1'b0, 1'b0, '0, '0, SEL, 1'b0, 1'b0, AW'(8), '0);
        chk_val("R8 x word stored", ry_en, ry_d, 36'h1_2345_6789);
        cyc(SEL, 1'b0, 1'b0, AW'(9), '0, SEL, 1'b1, 1'b0, AW'(9), 36'h2_468A_CE02);
        chk_val("R8 x sees old word", rx_en, rx_d, pat_b(9));
        cyc(SEL, 1'b0, 1'b0, AW'(9), '0, NOSEL, 1'b0, 1'b0, '0, '0);
        chk_val("R8 y word stored", rx_en, rx_d, 36'h2_468A_CE02);

        // R9: both write the same address
        cyc(SEL, 1'b1, 1'b0, AW'(10), 36'h3_3333_0001, SEL, 1'b1, 1'b0, AW'(10), 36'h4_4444_0002);
        cyc(SEL, 1'b0, 1'b0, AW'(10), '0, NOSEL, 1'b0, 1'b0, '0, '0);
        chk_val("R9 y word kept", rx_en, rx_d, 36'h4_4444_0002);

        // R5: X forwards to Y, overriding Y's read; X still reads its own address
        cyc(SEL, 1'b0, 1'b1, AW'(12), 36'h5_0F0F_5A5A, SEL, 1'b0, 1'b0, AW'(11), '0);
        chk_val("R5 y gets forwarded word", ry_en, ry_d, 36'h5_0F0F_5A5A);
        chk_val("R5 x own read", rx_en, rx_d, pat_b(12));
        cyc(NOSEL, 1'b0, 1'b0, '0, '0, SEL, 1'b0, 1'b0, AW'(12), '0);
        chk_val("R5 forward does not write", ry_en, ry_d, pat_b(12));
        cyc(SEL, 1'b0, 1'b1, AW'(0), 36'h6_1234_ABCD, NOSEL, 1'b0, 1'b0, '0, '0);
        chk_val("R5 forward to idle y", ry_en, ry_d, 36'h6_1234_ABCD);

        // R6: Y forwards to X; then both forward and swap
        cyc(SEL, 1'b0, 1'b0, AW'(13), '0, SEL, 1'b0, 1'b1, AW'(14), 36'h7_7654_3210);
        chk_val("R6 x gets forwarded word", rx_en, rx_d, 36'h7_7654_3210);
        chk_val("R6 y own read", ry_en, ry_d, pat_b(14));
        cyc(SEL, 1'b0, 1'b1, AW'(1), 36'h0_AAAA_5555, SEL, 1'b0, 1'b1, AW'(2), 36'h0_5555_AAAA);
        chk_val("R6 swap into x", rx_en, rx_d, 36'h0_5555_AAAA);
        chk_val("R5 swap into y", ry_en, ry_d, 36'h0_AAAA_5555);

        // R10: the first edge after reset release drops its operation
        rst_n = 1'b0;
        step(); step();
        chk_off("R12 x in second reset", x_dout_en);
        rst_n = 1'b1;
        cyc(SEL, 1'b1, 1'b0, AW'(3), 36'h8_0000_0003, NOSEL, 1'b0, 1'b0, '0, '0);
        cyc(NOSEL, 1'b0, 1'b0, '0, '0, SEL, 1'b0, 1'b0, AW'(3), '0);
        chk_val("R10 warm write dropped", ry_en, ry_d, pat_b(3));
        cyc(SEL, 1'b1, 1'b0, AW'(4), 36'h8_0000_0004, NOSEL, 1'b0, 1'b0, '0, '0);
        cyc(NOSEL, 1'b0, 1'b0, '0, '0, SEL, 1'b0, 1'b0, AW'(4), '0);
        chk_val("R10 later write accepted", ry_en, ry_d, 36'h8_0000_0004);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule